// File: doc/BRIEF.md
# Flash Embedded-Operation Status Word Generator

This block forms the word a flash device returns on a read while an internal program or erase is active, suspended, finished or has failed, and it drives the ready output. A controller elsewhere tells it the current operation mode, bit 7 of the data being programmed, whether the read address lies in a sector chosen for erase, whether the operation has run past its time limit, and whether the target is protected. The block registers one output word per read strobe. Array data from outside is passed through whenever plain data is the right answer.

The toggle bits are kept in flip-flops that change only on a read strobe. Two reads in a row during activity therefore always return different toggle bits, however many clocks pass between them. An attempt on a protected target shows in-progress status for a fixed number of cycles. After that the block answers as in read-array mode until the controller returns to idle.

Top module: `flash_status_gen`

## Requirements
- R1: With `op_mode`=1 (program), a read returns bit7 = inverse of `prog_d7`, bit6 = toggle value, bit5 = time-limit flag, bits 4..0 = 0. `ready` is low from the clock after the mode is applied.
- R2: With `op_mode`=3 (erase running), a read returns bit7=0, bit6 toggling, bit3=1 and bit5 = time-limit flag. Bit2 toggles when `in_ers_sector`=1 and is 0 otherwise. `ready` is low.
- R3: With `op_mode`=2 (erase time-out window), reads follow R2 except that bit3=0.
- R4: A `time_over` pulse during modes 1, 2, 3 or 5 sets bit5 of later status reads while bit6 keeps toggling, bit7 keeps its in-progress value and `ready` stays low. The flag clears on `reset_cmd` or when `op_mode`=0.
- R5: With `op_mode`=0 (or the unused codes 6, 7), reads return `array_data` unchanged, `ready` is high, and the toggle state does not advance.
- R6: With `op_mode`=4 (erase suspended) and `in_ers_sector`=1, a read returns bit7=1, bit6 held at its last value, bit2 toggling and all other bits 0. `ready` is high.
- R7: With `op_mode`=4 and `in_ers_sector`=0, a read returns `array_data` and `ready` is high.
- R8: With `op_mode`=5 (program during suspend), reads behave as in R1.
- R9: With `prot_target`=1 in program modes, status stays in progress for PROT_PGM_CYC clocks. After that, reads return `array_data` and `ready` is high until `op_mode` returns to 0.
- R10: With `prot_target`=1 in erase modes, the in-progress window lasts PROT_ERS_CYC clocks (default 5000). It is still in progress at PROT_PGM_CYC+10 clocks.
- R11: `rd_data` changes only on the clock edge that samples `rd_stb`=1, one cycle after the strobe. Toggle bits advance only on such strobes.
- R12: Word bits outside 7, 6, 5, 3 and 2 read 0 in every status answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_mode | input | 3 | 0 idle, 1 program, 2 erase window, 3 erase running, 4 erase suspended, 5 suspended program |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| in_ers_sector | input | 1 | Read address lies in a sector selected for erase |
| time_over | input | 1 | Operation exceeded its time limit |
| prot_target | input | 1 | Operation targets a protected sector |
| reset_cmd | input | 1 | Reset command seen, clears the time-limit flag |
| rd_stb | input | 1 | Read strobe, one clock wide per read |
| array_data | input | DATA_W | Array contents at the read address |
| rd_data | output | DATA_W | Registered read word |
| ready | output | 1 | High when no operation is active |

## Verification
The assertions assume that `rd_stb` is a one-clock pulse per read, that `op_mode` only takes codes 0 to 7 with 6 and 7 treated as idle, and that `prot_target` stays constant for the length of an operation. The stimulus meets these assumptions. It holds each mode for a segment, changes the mode only between reads, and pulses `time_over` and `reset_cmd` for single cycles. Random segments keep `prot_target` low. The protected windows are driven in directed runs that hold it steady until the mode returns to idle.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [2:0] {
        MD_IDLE     = 3'd0,
        MD_PGM      = 3'd1,
        MD_ERS_WIN  = 3'd2,
        MD_ERS_RUN  = 3'd3,
        MD_SUSP     = 3'd4,
        MD_SUSP_PGM = 3'd5
    } op_mode_e;

    localparam int unsigned Q7_BIT = 7;
    localparam int unsigned Q6_BIT = 6;
    localparam int unsigned Q5_BIT = 5;
    localparam int unsigned Q3_BIT = 3;
    localparam int unsigned Q2_BIT = 2;

endpackage

// File: rtl/fsg_prot_timer.sv
module fsg_prot_timer #(
    parameter int unsigned PGM_CYC = 50,
    parameter int unsigned ERS_CYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic is_erase,
    input  logic clear,
    output logic done
);
    localparam int unsigned LIM_MAX = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC;
    localparam int unsigned CW      = $clog2(LIM_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        last_cnt = is_erase ? CW'(ERS_CYC - 1) : CW'(PGM_CYC - 1);
        tmr_d    = tmr_q;
        if (clear) begin
            tmr_d = '0;
        end else if (!tmr_q.done) begin
            if (run) begin
                if (tmr_q.cnt == last_cnt) begin
                    tmr_d.done = 1'b1;
                end else begin
                    tmr_d.cnt = tmr_q.cnt + 1'b1;
                end
            end else begin
                tmr_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign done = tmr_q.done;
endmodule

// File: rtl/fsg_status_enc.sv
module fsg_status_enc
    import flash_stat_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic [2:0]        mode,
    input  logic              prog_d7,
    input  logic              in_sector,
    input  logic              fail,
    input  logic              prot_done,
    input  logic              t6,
    input  logic              t2,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] word,
    output logic              tog6_en,
    output logic              tog2_en,
    output logic              busy
);
    op_mode_e md;

    always_comb begin
        md      = op_mode_e'(mode);
        word    = '0;
        tog6_en = 1'b0;
        tog2_en = 1'b0;
        busy    = 1'b0;
        case (md)
            MD_PGM, MD_SUSP_PGM: begin
                if (prot_done) begin
                    word = array_data;
                end else begin
                    word[Q7_BIT] = ~prog_d7;
                    word[Q6_BIT] = t6;
                    word[Q5_BIT] = fail;
                    tog6_en      = 1'b1;
                    busy         = 1'b1;
                end
            end
            MD_ERS_WIN, MD_ERS_RUN: begin
                if (prot_done) begin
                    word = array_data;
                end else begin
                    word[Q6_BIT] = t6;
                    word[Q5_BIT] = fail;
                    word[Q3_BIT] = (md == MD_ERS_RUN);
                    word[Q2_BIT] = in_sector & t2;
                    tog6_en      = 1'b1;
                    tog2_en      = in_sector;
                    busy         = 1'b1;
                end
            end
            MD_SUSP: begin
                if (in_sector) begin
                    word[Q7_BIT] = 1'b1;
                    word[Q6_BIT] = t6;
                    word[Q2_BIT] = t2;
                    tog2_en      = 1'b1;
                end else begin
                    word = array_data;
                end
            end
            default: word = array_data;
        endcase
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_stat_pkg::*;
#(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned PROT_PGM_CYC = 50,
    parameter int unsigned PROT_ERS_CYC = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_mode,
    input  logic              prog_d7,
    input  logic              in_ers_sector,
    input  logic              time_over,
    input  logic              prot_target,
    input  logic              reset_cmd,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);
    typedef struct packed {
        logic [DATA_W-1:0] rdat;
        logic              t6;
        logic              t2;
        logic              fail;
        logic              rdy;
    } st_t;

    st_t st_d, st_q;

    logic              is_pgm, is_ers, active, is_idle;
    logic              prot_done;
    logic [DATA_W-1:0] word;
    logic              tog6_en, tog2_en, busy;

    always_comb begin
        is_pgm  = (op_mode == MD_PGM) || (op_mode == MD_SUSP_PGM);
        is_ers  = (op_mode == MD_ERS_WIN) || (op_mode == MD_ERS_RUN);
        active  = is_pgm || is_ers;
        is_idle = !active && (op_mode != MD_SUSP);
    end

    fsg_prot_timer #(
        .PGM_CYC (PROT_PGM_CYC),
        .ERS_CYC (PROT_ERS_CYC)
    ) prot_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active && prot_target),
        .is_erase (is_ers),
        .clear    (is_idle),
        .done     (prot_done)
    );

    fsg_status_enc #(
        .DATA_W (DATA_W)
    ) enc_i (
        .mode       (op_mode),
        .prog_d7    (prog_d7),
        .in_sector  (in_ers_sector),
        .fail       (st_q.fail),
        .prot_done  (prot_done),
        .t6         (st_q.t6),
        .t2         (st_q.t2),
        .array_data (array_data),
        .word       (word),
        .tog6_en    (tog6_en),
        .tog2_en    (tog2_en),
        .busy       (busy)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = !busy;
        if (reset_cmd || is_idle) begin
            st_d.fail = 1'b0;
        end else if (time_over && active) begin
            st_d.fail = 1'b1;
        end
        if (rd_stb) begin
            st_d.rdat = word;
            st_d.t6   = st_q.t6 ^ tog6_en;
            st_d.t2   = st_q.t2 ^ tog2_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rdy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rdat;
    assign ready   = st_q.rdy;
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_mode,
    input logic              prog_d7,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic              ready,
    input logic              fail_q,
    input logic              prot_done
);
    logic pgm_rd;
    assign pgm_rd = rd_stb && (op_mode == 3'd1) && !prot_done;

    AST_PGM_Q7_INV: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_rd |=> (rd_data[7] == !$past(prog_d7))); // R1

    AST_PGM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_mode == 3'd1) && !prot_done) |=> !ready); // R1

    AST_PGM_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_rd && $past(pgm_rd)) |=> (rd_data[6] != $past(rd_data[6]))); // R11

    AST_FAIL_Q5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && (op_mode == 3'd3) && fail_q && !prot_done) |=> rd_data[5]); // R4

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd0) |=> ready); // R5

    AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'd4) |=> ready); // R6

    AST_HOLD_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data)); // R11

    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_rd |=> (rd_data[4:0] == 5'd0)); // R12
endmodule

bind flash_status_gen flash_status_gen_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_mode   (op_mode),
    .prog_d7   (prog_d7),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .ready     (ready),
    .fail_q    (st_q.fail),
    .prot_done (prot_done)
);

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
    localparam int unsigned PGM_LIM = 50;
    localparam int unsigned ERS_LIM = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_mode = 3'd0;
    logic       prog_d7 = 1'b0;
    logic       in_ers_sector = 1'b0;
    logic       time_over = 1'b0;
    logic       prot_target = 1'b0;
    logic       reset_cmd = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] array_data = 8'h00;
    logic [7:0] rd_data;
    logic       ready;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // bench reference state
    logic m6 = 1'b0;
    logic m2 = 1'b0;
    logic m_fail = 1'b0;
    logic m_pdone = 1'b0;

    always #10 clk = ~clk;

    flash_status_gen #(
        .DATA_W       (8),
        .PROT_PGM_CYC (PGM_LIM),
        .PROT_ERS_CYC (ERS_LIM)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_mode       (op_mode),
        .prog_d7       (prog_d7),
        .in_ers_sector (in_ers_sector),
        .time_over     (time_over),
        .prot_target   (prot_target),
        .reset_cmd     (reset_cmd),
        .rd_stb        (rd_stb),
        .array_data    (array_data),
        .rd_data       (rd_data),
        .ready         (ready)
    );

    function automatic logic is_pgm_m(input logic [2:0] m);
        return (m == 3'd1) || (m == 3'd5);
    endfunction

    function automatic logic is_ers_m(input logic [2:0] m);
        return (m == 3'd2) || (m == 3'd3);
    endfunction

    function automatic logic [7:0] exp_word(input logic [2:0] m, input logic [7:0] arr);
        logic [7:0] w;
        w = 8'h00;
        if (is_pgm_m(m) && !m_pdone) begin
            w[7] = ~prog_d7; w[6] = m6; w[5] = m_fail;
        end else if (is_ers_m(m) && !m_pdone) begin
            w[6] = m6; w[5] = m_fail; w[3] = (m == 3'd3);
            w[2] = in_ers_sector & m2;
        end else if (m == 3'd4 && in_ers_sector) begin
            w[7] = 1'b1; w[6] = m6; w[2] = m2;
        end else begin
            w = arr;
        end
        return w;
    endfunction

    function automatic string tag_of(input logic [2:0] m);
        if (m_pdone) return "R9";
        if (m_fail && (is_pgm_m(m) || is_ers_m(m))) return "R4";
        case (m)
            3'd1: return "R1";
            3'd2: return "R3";
            3'd3: return "R2";
            3'd4: return in_ers_sector ? "R6" : "R7";
            3'd5: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_read(input logic [7:0] arr, input string tag);
        logic [7:0] e;
        @(negedge clk);
        array_data = arr;
        rd_stb     = 1'b1;
        e = exp_word(op_mode, arr);
        if (is_pgm_m(op_mode) && !m_pdone) m6 = ~m6;
        else if (is_ers_m(op_mode) && !m_pdone) begin
            m6 = ~m6;
            if (in_ers_sector) m2 = ~m2;
        end else if (op_mode == 3'd4 && in_ers_sector) m2 = ~m2;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(tag, rd_data, e);
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        op_mode = m;
        if (!(is_pgm_m(m) || is_ers_m(m)) && m != 3'd4) begin
            m_fail  = 1'b0;
            m_pdone = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] hold_v;
        void'($urandom(32'h5A17));
        wait_cyc(3);
        // reset state
        chk("R5 reset data", rd_data, 8'h00);
        chk("R5 reset ready", {7'd0, ready}, 8'h01);
        rst_n = 1'b1;
        wait_cyc(2);

        // directed: idle passthrough, no toggle
        do_read(8'hA5, "R5");
        do_read(8'h3C, "R5");

        // directed: program back-to-back toggle, complement
        prog_d7 = 1'b1;
        set_mode(3'd1);
        chk("R1 busy", {7'd0, ready}, 8'h00);
        do_read(8'hFF, "R1");
        do_read(8'hFF, "R1");
        hold_v = rd_data;
        wait_cyc(4);
        chk("R11 hold", rd_data, hold_v);

        // directed: time limit in erase run with sector hit
        in_ers_sector = 1'b1;
        set_mode(3'd3);
        @(negedge clk); time_over = 1'b1;
        @(negedge clk); time_over = 1'b0; m_fail = 1'b1;
        do_read(8'h00, "R4");
        do_read(8'h00, "R4");
        chk("R4 busy", {7'd0, ready}, 8'h00);
        @(negedge clk); reset_cmd = 1'b1;
        @(negedge clk); reset_cmd = 1'b0; m_fail = 1'b0;
        do_read(8'h00, "R4 cleared");

        // directed: suspend in sector / outside
        set_mode(3'd4);
        chk("R6 ready", {7'd0, ready}, 8'h01);
        do_read(8'h11, "R6");
        do_read(8'h11, "R6");
        in_ers_sector = 1'b0;
        do_read(8'h5E, "R7");
        set_mode(3'd0);

        // random segments
        for (int s = 0; s < 80; s++) begin
            logic [2:0] m;
            m = 3'($urandom % 8);
            prog_d7       = 1'($urandom);
            in_ers_sector = 1'($urandom);
            set_mode(m);
            if ((is_pgm_m(m) || is_ers_m(m)) && ($urandom % 3 == 0)) begin
                @(negedge clk); time_over = 1'b1;
                @(negedge clk); time_over = 1'b0; m_fail = 1'b1;
            end
            if ($urandom % 5 == 0) begin
                @(negedge clk); reset_cmd = 1'b1;
                @(negedge clk); reset_cmd = 1'b0; m_fail = 1'b0;
            end
            chk(is_pgm_m(m) || is_ers_m(m) ? "R1 ready" : "R5 ready",
                {7'd0, ready}, {7'd0, !(is_pgm_m(m) || is_ers_m(m))});
            for (int r = 0; r < 1 + int'($urandom % 4); r++) begin
                do_read(8'($urandom), tag_of(m));
                if (r == 1) in_ers_sector = 1'($urandom);
            end
        end
        set_mode(3'd0);

        // directed: protected program
        prog_d7 = 1'b0;
        @(negedge clk); prot_target = 1'b1; op_mode = 3'd1;
        wait_cyc(8);
        do_read(8'h42, "R9 in progress");
        chk("R9 busy", {7'd0, ready}, 8'h00);
        wait_cyc(PGM_LIM);
        m_pdone = 1'b1;
        do_read(8'h42, "R9 done");
        chk("R9 ready", {7'd0, ready}, 8'h01);
        @(negedge clk); prot_target = 1'b0;
        set_mode(3'd0);

        // directed: protected erase
        in_ers_sector = 1'b0;
        @(negedge clk); prot_target = 1'b1; op_mode = 3'd3;
        wait_cyc(PGM_LIM + 10);
        do_read(8'h99, "R10 in progress");
        chk("R10 busy", {7'd0, ready}, 8'h00);
        wait_cyc(ERS_LIM);
        m_pdone = 1'b1;
        do_read(8'h99, "R10 done");
        chk("R10 ready", {7'd0, ready}, 8'h01);
        @(negedge clk); prot_target = 1'b0;
        set_mode(3'd0);
        do_read(8'h00, "R12 idle");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule